// File: doc/BRIEF.md
# Decode Hazard Interlock

This block is the control half of the decode stage of a five-stage in-order pipeline that has no forwarding paths. Each cycle it looks at the instruction waiting in the fetch/decode latch and works out which registers it reads and which one it writes. It then compares the source registers against the destination of every older instruction still in flight downstream. If any of those older instructions will write a register that the new one reads, decode holds the instruction until the producer has reached writeback.

It also manages the single control hazard of the instruction set, the branch-if-equal. Issuing a branch raises a fetch freeze. The freeze stays up until execute reports that the branch has resolved. Any instruction found in the fetch/decode latch while the freeze is up is thrown away.

Operands move forward only into an empty decode/execute latch. An immediate that cannot be held in a 16-bit two's complement field stops decode for good. Register numbers are 5-bit fields, so every value from 0 to 31 is legal.

Top module: `dec_interlock`

## Requirements
- R1: After reset, `fetch_freeze`, `dec_fault`, `de_load` and `fd_consume` are all 0 while `fd_valid` is 0.
- R2: `fd_op` uses this encoding: 0 add, 1 sub, 2 mul, 3 addi, 4 lw, 5 sw, 6 beq, 7 halt. R-types (0..2) read `fd_rs`/`fd_rt` and write `fd_rd`. addi and lw read `fd_rs` and write `fd_rt`. sw and beq read `fd_rs`/`fd_rt` and write nothing. halt reads nothing. `dec_wr` is 1 exactly for opcodes 0..4, and `dec_dst` then names the written register.
- R3: Slot i of the in-flight inputs holds `ahd_valid[i]`, `ahd_wr[i]` and `ahd_dst[i*5 +: 5]`. A live slot that is valid, is writing, and has a destination equal to a register the decoding instruction reads makes `raw_stall` 1. In that case `de_load` and `fd_consume` are both 0 in the same cycle.
- R4: A slot never causes a stall if its destination is register 0, if it is not writing, or if it is not valid. A destination that matches only an unread field (for example the rt of addi) never causes a stall either.
- R5: The highest slot is the instruction writing back in the current cycle. Its destination never causes a stall.
- R6: When no hazard exists but `de_full` is 1, `slot_stall` is 1 and `de_load` and `fd_consume` are 0.
- R7: When no hazard exists and `de_full` is 0, `de_load` and `fd_consume` are 1 in the same cycle that `fd_valid` is presented.
- R8: Loading a beq raises `fetch_freeze` from the next cycle on. The freeze stays up through the cycle in which `br_resolve` is 1 and drops in the cycle after it.
- R9: While `fetch_freeze` is 1, a valid fetch/decode entry is discarded: `fd_consume` is 1 and `de_load` is 0.
- R10: For opcodes 3..6, an `fd_imm` outside -32768..32767 blocks the load and `fd_consume`. `dec_fault` then rises in the next cycle and stays 1 until reset, and from then on no load occurs. For opcodes 0..2 and 7 the immediate has no effect.
- R11: `dec_imm_sx` is the low 16 bits of `fd_imm` sign-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fd_valid | input | 1 | Fetch/decode latch holds an instruction |
| fd_op | input | 3 | Opcode of that instruction |
| fd_rs | input | 5 | First source register field |
| fd_rt | input | 5 | Second source / immediate-form destination field |
| fd_rd | input | 5 | R-type destination field |
| fd_imm | input | 32 | Immediate value before range check |
| ahd_valid | input | 3 | Per in-flight slot: occupied |
| ahd_wr | input | 3 | Per in-flight slot: writes a register |
| ahd_dst | input | 15 | Per in-flight slot: destination, 5 bits each |
| de_full | input | 1 | Decode/execute latch valid bit |
| br_resolve | input | 1 | Execute has resolved the pending branch |
| fd_consume | output | 1 | Clear the fetch/decode latch at this edge |
| de_load | output | 1 | Write the decode/execute latch at this edge |
| raw_stall | output | 1 | Held by a read-after-write hazard |
| slot_stall | output | 1 | Held because the decode/execute latch is full |
| fetch_freeze | output | 1 | Fetch must idle (branch pending) |
| dec_wr | output | 1 | Decoded instruction writes a register |
| dec_dst | output | 5 | Decoded destination register |
| dec_imm_sx | output | 32 | Sign-extended immediate |
| dec_fault | output | 1 | Sticky immediate-range fault |

## Verification
All stall, load, consume and decode outputs are combinational on the current inputs and registered state. The bench therefore checks them 1 ns after applying a vector, inside the same cycle, and withdraws `fd_valid` before the next rising edge so that the sweeps never change the state. The two registered results are the branch freeze and the fault flag. Each is due exactly one rising edge after its cause, so the bench checks it at the next falling edge. The freeze release is checked in the same way, one edge after `br_resolve`.

// File: rtl/dec_pkg.sv
package dec_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_MUL  = 3'd2,
      OP_ADDI = 3'd3,
      OP_LW   = 3'd4,
      OP_SW   = 3'd5,
      OP_BEQ  = 3'd6,
      OP_HALT = 3'd7
   } op_e;

   // Which fields an opcode touches.
   typedef struct packed {
      logic reads_a;   // reads rs
      logic reads_b;   // reads rt
      logic writes;    // produces a register
      logic dst_is_rt; // destination field is rt instead of rd
      logic has_imm;   // immediate must pass the range check
      logic is_br;     // control-transfer
   } dec_ctl_t;

   function automatic dec_ctl_t ctl_of(op_e op);
      dec_ctl_t c;
      c = '0;
      unique case (op)
         OP_ADD, OP_SUB, OP_MUL: begin
            c.reads_a = 1'b1; c.reads_b = 1'b1; c.writes = 1'b1;
         end
         OP_ADDI, OP_LW: begin
            c.reads_a = 1'b1; c.writes = 1'b1; c.dst_is_rt = 1'b1; c.has_imm = 1'b1;
         end
         OP_SW: begin
            c.reads_a = 1'b1; c.reads_b = 1'b1; c.has_imm = 1'b1;
         end
         OP_BEQ: begin
            c.reads_a = 1'b1; c.reads_b = 1'b1; c.has_imm = 1'b1; c.is_br = 1'b1;
         end
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/dec_fields.sv
module dec_fields
   import dec_pkg::*;
#(
   parameter int RW       = 5,
   parameter int IMM_IN_W = 32,
   parameter int IMM_W    = 16
) (
   input  logic [2:0]          op_raw,
   input  logic [RW-1:0]       rt,
   input  logic [RW-1:0]       rd,
   input  logic [IMM_IN_W-1:0] imm,
   output dec_ctl_t            ctl,
   output logic [RW-1:0]       dst,
   output logic                imm_bad,
   output logic [IMM_IN_W-1:0] imm_sx
);

   localparam int EXT_W = IMM_IN_W - IMM_W;

   always_comb begin
      ctl = ctl_of(op_e'(op_raw));
      if (!ctl.writes)
         dst = '0;
      else if (ctl.dst_is_rt)
         dst = rt;
      else
         dst = rd;
   end

   generate
      if (EXT_W == 0) begin : g_full_imm
         assign imm_sx  = imm;
         assign imm_bad = 1'b0;
      end else begin : g_narrow_imm
         logic fits;
         // Representable iff all bits from the sign bit upward agree.
         assign fits    = (&imm[IMM_IN_W-1:IMM_W-1]) | ~(|imm[IMM_IN_W-1:IMM_W-1]);
         assign imm_bad = ctl.has_imm & ~fits;
         assign imm_sx  = {{EXT_W{imm[IMM_W-1]}}, imm[IMM_W-1:0]};
      end
   endgenerate

endmodule

// File: rtl/dec_raw_scan.sv
module dec_raw_scan #(
   parameter int RW        = 5,
   parameter int NUM_AHEAD = 3,
   parameter bit WB_SPLIT  = 1'b1
) (
   input  logic                    reads_a,
   input  logic                    reads_b,
   input  logic [RW-1:0]           src_a,
   input  logic [RW-1:0]           src_b,
   input  logic [NUM_AHEAD-1:0]    ahd_valid,
   input  logic [NUM_AHEAD-1:0]    ahd_wr,
   input  logic [NUM_AHEAD*RW-1:0] ahd_dst,
   output logic                    hit
);

   localparam int LAST = NUM_AHEAD - 1;

   logic [NUM_AHEAD-1:0] slot_hit;

   generate
      for (genvar i = 0; i < NUM_AHEAD; i++) begin : g_slot
         logic [RW-1:0] d;
         logic          producer;
         logic          match;
         assign d        = ahd_dst[i*RW +: RW];
         assign producer = ahd_valid[i] & ahd_wr[i] & (|d);
         assign match    = (reads_a & (d == src_a)) | (reads_b & (d == src_b));
         if (WB_SPLIT && i == LAST) begin : g_wb_slot
            // Written in the first half of this cycle, read in the second.
            assign slot_hit[i] = 1'b0 & producer & match;
         end else begin : g_live_slot
            assign slot_hit[i] = producer & match;
         end
      end
   endgenerate

   assign hit = |slot_hit;

endmodule

// File: rtl/dec_state.sv
module dec_state (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_br,
   input  logic resolve,
   input  logic fault_now,
   output logic pend,
   output logic stopped
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         stopped <= 1'b0;
      end else begin
         if (issue_br)
            pend <= 1'b1;
         else if (resolve)
            pend <= 1'b0;
         if (fault_now)
            stopped <= 1'b1;
      end
   end

endmodule

// File: rtl/dec_interlock.sv
module dec_interlock
   import dec_pkg::*;
#(
   parameter int RW        = 5,
   parameter int NUM_AHEAD = 3,
   parameter int IMM_IN_W  = 32,
   parameter int IMM_W     = 16,
   parameter bit WB_SPLIT  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fd_valid,
   input  logic [2:0]              fd_op,
   input  logic [RW-1:0]           fd_rs,
   input  logic [RW-1:0]           fd_rt,
   input  logic [RW-1:0]           fd_rd,
   input  logic [IMM_IN_W-1:0]     fd_imm,
   input  logic [NUM_AHEAD-1:0]    ahd_valid,
   input  logic [NUM_AHEAD-1:0]    ahd_wr,
   input  logic [NUM_AHEAD*RW-1:0] ahd_dst,
   input  logic                    de_full,
   input  logic                    br_resolve,
   output logic                    fd_consume,
   output logic                    de_load,
   output logic                    raw_stall,
   output logic                    slot_stall,
   output logic                    fetch_freeze,
   output logic                    dec_wr,
   output logic [RW-1:0]           dec_dst,
   output logic [IMM_IN_W-1:0]     dec_imm_sx,
   output logic                    dec_fault
);

   generate
      if (RW < 1) begin : g_bad_rw
         $error("RW must be at least 1");
      end
      if (IMM_W < 2 || IMM_W > IMM_IN_W) begin : g_bad_imm
         $error("IMM_W must lie in 2..IMM_IN_W");
      end
      if (NUM_AHEAD < 1 || NUM_AHEAD <= int'(WB_SPLIT)) begin : g_bad_ahead
         $error("NUM_AHEAD must leave at least one live slot");
      end
   endgenerate

   dec_ctl_t ctl;
   logic     imm_bad;
   logic     raw_hit;
   logic     pend;
   logic     stopped;
   logic     live;
   logic     clear_path;
   logic     fault_now;

   dec_fields #(
      .RW(RW), .IMM_IN_W(IMM_IN_W), .IMM_W(IMM_W)
   ) u_fields (
      .op_raw  (fd_op),
      .rt      (fd_rt),
      .rd      (fd_rd),
      .imm     (fd_imm),
      .ctl     (ctl),
      .dst     (dec_dst),
      .imm_bad (imm_bad),
      .imm_sx  (dec_imm_sx)
   );

   dec_raw_scan #(
      .RW(RW), .NUM_AHEAD(NUM_AHEAD), .WB_SPLIT(WB_SPLIT)
   ) u_scan (
      .reads_a   (ctl.reads_a),
      .reads_b   (ctl.reads_b),
      .src_a     (fd_rs),
      .src_b     (fd_rt),
      .ahd_valid (ahd_valid),
      .ahd_wr    (ahd_wr),
      .ahd_dst   (ahd_dst),
      .hit       (raw_hit)
   );

   assign live       = fd_valid & ~stopped;
   assign clear_path = live & ~pend & ~imm_bad;
   assign fault_now  = live & ~pend & imm_bad;

   assign raw_stall  = clear_path & raw_hit;
   assign slot_stall = clear_path & ~raw_hit & de_full;
   assign de_load    = clear_path & ~raw_hit & ~de_full;
   assign fd_consume = de_load | (live & pend);

   assign dec_wr       = ctl.writes;
   assign fetch_freeze = pend;
   assign dec_fault    = stopped;

   dec_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_br  (de_load & ctl.is_br),
      .resolve   (br_resolve),
      .fault_now (fault_now),
      .pend      (pend),
      .stopped   (stopped)
   );

endmodule

// File: rtl/dec_interlock_chk.sv
module dec_interlock_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fd_valid,
   input logic [2:0] fd_op,
   input logic       de_full,
   input logic       br_resolve,
   input logic       fd_consume,
   input logic       de_load,
   input logic       raw_stall,
   input logic       slot_stall,
   input logic       fetch_freeze,
   input logic       dec_fault
);

   assert_load_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      de_load |-> fd_valid && fd_consume);

   assert_raw_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      raw_stall |-> !de_load && !fd_consume);

   assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      de_full |-> !de_load);

   assert_slot_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stall |-> de_full && !de_load);

   assert_freeze_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_freeze) |-> $past(de_load && fd_op == 3'd6));

   assert_freeze_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fetch_freeze) |-> $past(br_resolve));

   assert_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_freeze |-> !de_load);

   assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fault |=> dec_fault);

   assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fault |-> !de_load && !fd_consume);

endmodule

bind dec_interlock dec_interlock_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fd_valid     (fd_valid),
   .fd_op        (fd_op),
   .de_full      (de_full),
   .br_resolve   (br_resolve),
   .fd_consume   (fd_consume),
   .de_load      (de_load),
   .raw_stall    (raw_stall),
   .slot_stall   (slot_stall),
   .fetch_freeze (fetch_freeze),
   .dec_fault    (dec_fault)
);

// File: tb/test_dec_interlock.sv
`timescale 1ns/1ps
module test_dec_interlock;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fd_valid = 1'b0;
   logic [2:0]  fd_op = '0;
   logic [4:0]  fd_rs = 5'd5, fd_rt = 5'd9, fd_rd = 5'd12;
   logic [31:0] fd_imm = '0;
   logic [2:0]  ahd_valid = '0, ahd_wr = '0;
   logic [14:0] ahd_dst = '0;
   logic        de_full = 1'b0, br_resolve = 1'b0;
   logic        fd_consume, de_load, raw_stall, slot_stall, fetch_freeze;
   logic        dec_wr, dec_fault;
   logic [4:0]  dec_dst;
   logic [31:0] dec_imm_sx;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dec_interlock i_dec_interlock (
      .clk(clk), .rst_n(rst_n), .fd_valid(fd_valid), .fd_op(fd_op),
      .fd_rs(fd_rs), .fd_rt(fd_rt), .fd_rd(fd_rd), .fd_imm(fd_imm),
      .ahd_valid(ahd_valid), .ahd_wr(ahd_wr), .ahd_dst(ahd_dst),
      .de_full(de_full), .br_resolve(br_resolve),
      .fd_consume(fd_consume), .de_load(de_load), .raw_stall(raw_stall),
      .slot_stall(slot_stall), .fetch_freeze(fetch_freeze), .dec_wr(dec_wr),
      .dec_dst(dec_dst), .dec_imm_sx(dec_imm_sx), .dec_fault(dec_fault)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit reads_a(int op); return op != 7; endfunction
   function automatic bit reads_b(int op); return op <= 2 || op == 5 || op == 6; endfunction
   function automatic bit writes(int op);  return op <= 4; endfunction

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 freeze", fetch_freeze, 0);
      chk("R1 fault", dec_fault, 0);
      chk("R1 load", de_load, 0);
      chk("R1 consume", fd_consume, 0);

      // R2..R5, R7 sweep: opcode x slot x destination x valid x write
      for (int op = 0; op < 8; op++)
         for (int s = 0; s < 3; s++)
            for (int ds = 0; ds < 4; ds++)
               for (int v = 0; v < 2; v++)
                  for (int w = 0; w < 2; w++) begin
                     logic [4:0] d;
                     bit exp_raw;
                     d = (ds == 0) ? 5'd0 : (ds == 1) ? 5'd5 : (ds == 2) ? 5'd9 : 5'd12;
                     @(negedge clk);
                     fd_op = op[2:0]; fd_imm = 32'd4; fd_valid = 1'b1;
                     ahd_valid = '0; ahd_wr = '0; ahd_dst = '0;
                     ahd_valid[s] = v[0]; ahd_wr[s] = w[0]; ahd_dst[s*5 +: 5] = d;
                     exp_raw = (s < 2) && v && w && d != 0 &&
                               ((reads_a(op) && d == 5'd5) || (reads_b(op) && d == 5'd9));
                     #1;
                     if (s == 2)
                        chk("R5 wb slot", {raw_stall, de_load}, {1'b0, 1'b1});
                     else if (exp_raw)
                        chk("R3 raw", {raw_stall, de_load, fd_consume}, {3'b100});
                     else
                        chk("R4 no hazard", {raw_stall, de_load, fd_consume}, {3'b011});
                     chk("R2 wr", dec_wr, writes(op));
                     if (writes(op))
                        chk("R2 dst", dec_dst, (op <= 2) ? 5'd12 : 5'd9);
                     fd_valid = 1'b0;
                  end
      ahd_valid = '0;

      // R6 structural stall
      @(negedge clk);
      fd_op = 3'd0; fd_valid = 1'b1; de_full = 1'b1;
      #1;
      chk("R6 slot stall", {slot_stall, de_load, fd_consume}, 3'b100);
      de_full = 1'b0;
      #1;
      chk("R7 single cycle", {de_load, fd_consume}, 2'b11);
      fd_valid = 1'b0;

      // R11 sign extension and R10 boundaries that pass
      @(negedge clk);
      fd_op = 3'd3; fd_valid = 1'b1; fd_imm = 32'h0000_7FFF;
      #1;
      chk("R11 pos", dec_imm_sx, 32'h0000_7FFF);
      chk("R10 max ok", de_load, 1);
      fd_imm = 32'hFFFF_8000;
      #1;
      chk("R11 neg", dec_imm_sx, 32'hFFFF_8000);
      chk("R10 min ok", de_load, 1);
      fd_op = 3'd0; fd_imm = 32'h0001_0000;
      #1;
      chk("R10 rtype ignores imm", de_load, 1);
      fd_valid = 1'b0;

      // R8, R9 branch freeze
      @(negedge clk);
      fd_op = 3'd6; fd_imm = 32'd8; fd_valid = 1'b1;
      #1;
      chk("R8 beq load", de_load, 1);
      chk("R8 no freeze yet", fetch_freeze, 0);
      @(negedge clk);
      fd_op = 3'd0;
      chk("R8 freeze up", fetch_freeze, 1);
      #1;
      chk("R9 discard", {fd_consume, de_load}, 2'b10);
      fd_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 freeze held", fetch_freeze, 1);
      br_resolve = 1'b1;
      #1;
      chk("R8 freeze in resolve cycle", fetch_freeze, 1);
      @(negedge clk);
      br_resolve = 1'b0;
      chk("R8 freeze released", fetch_freeze, 0);
      fd_valid = 1'b1;
      #1;
      chk("R8 decode resumes", de_load, 1);
      fd_valid = 1'b0;

      // R10 out-of-range immediate
      @(negedge clk);
      fd_op = 3'd4; fd_imm = 32'h0000_8000; fd_valid = 1'b1;
      #1;
      chk("R10 blocked", {de_load, fd_consume, dec_fault}, 3'b000);
      @(negedge clk);
      chk("R10 fault raised", dec_fault, 1);
      fd_op = 3'd0; fd_imm = '0;
      #1;
      chk("R10 stopped", {de_load, fd_consume}, 2'b00);
      fd_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 sticky", dec_fault, 1);

      // R1 reset clears the fault
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 fault cleared", dec_fault, 0);
      fd_valid = 1'b1;
      #1;
      chk("R1 load after reset", de_load, 1);
      fd_valid = 1'b0;

      summary();
   end

endmodule